// File: doc/BRIEF.md
# In-Band Interrupt Requester for a Two-Wire Target

This block sits in the target side of an I3C-style two-wire bus and lets the target raise an interrupt without a separate wire. An internal client posts one request, optionally with a single payload byte. While that request is pending, the block watches the bus. When a START appears it joins the address header that follows and sends its own dynamic address, then a read bit. It drives SDA only through an open-drain pull-down enable and reads the resolved wire back, so it can tell when it loses the header to another target.

If the bus stays quiet long enough to count as available and no START has come, the block creates the START itself. It pulls SDA low while SCL is high and waits for the controller to clock the header. A target that loses arbitration, gets a NACK, or sees a STOP in mid-frame keeps its request. It ignores every later START until the bus has been available again, and then tries once more.

The request port is a valid/ready handshake. `req_ready` is high exactly when no request is pending. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_valid` seen while `req_ready` is low has no effect, and valid need not be held. SCL and SDA are expected already synchronised to `clk`.

Top module: `ibi_requester`

## Requirements
- R1: A request (address taken from `dyn_addr` at header time, payload flag and byte taken at acceptance) is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the request is delivered, and a `req_valid` pulse while it is low changes neither the pending payload nor anything else.
- R2: With a request pending and the block idle, a START (SDA falling while SCL is high) makes the block send an 8-bit header: the 7 address bits MSB first, then a 1. Each bit is placed after an SCL falling edge, and a 0 bit is sent by asserting `sda_pull_o`.
- R3: If the block releases SDA for a 1 bit but reads SDA low at the SCL rising edge, it pulses `lost_o` for one cycle and keeps `sda_pull_o` low for the rest of the frame.
- R4: When all 8 header bits pass without loss, `won_o` pulses for one cycle, and the SDA value at the next (ninth) SCL rising edge is taken as ACK (0) or NACK (1).
- R5: After a loss, a NACK or a STOP inside the frame, the request stays pending and the block does not drive SDA, even across new STARTs, until the bus-available condition has been reached.
- R6: Bus-available is reached when `tick_i` has been high on `avail_limit` clock edges while SCL and SDA stayed high. Either line low clears the count, and an `avail_limit` of 0 disables the condition.
- R7: With a request pending, the block idle and the bus available, the block asserts `sda_pull_o` while SCL is high (its own START) and keeps it until the controller lowers SCL, after which it sends the header as in R2.
- R8: After an ACK with a payload flagged, the block sends the 8 payload bits MSB first, then drives the ninth (end-of-data) bit as 0, releasing SDA at the next SCL falling edge.
- R9: `sent_o` pulses once when an ACKed header has no payload, or when the end-of-data bit of the payload completes. Only then is the request cleared.
- R10: With no request pending, the block never asserts `sda_pull_o`, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (resolved wire) |
| tick_i | input | 1 | Time base for the bus-available count |
| avail_limit | input | CNT_W | Ticks of idle bus needed for bus-available; 0 disables |
| dyn_addr | input | ADDR_W | Own dynamic address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | High when no request is pending |
| req_has_byte | input | 1 | Request carries a payload byte |
| req_byte | input | DATA_W | Payload byte |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| won_o | output | 1 | One-cycle pulse: header won |
| lost_o | output | 1 | One-cycle pulse: header arbitration lost |
| sent_o | output | 1 | One-cycle pulse: interrupt delivered |

## Verification
Checked on every cycle are the local invariants:
- the bus-available flag only with both lines high and a count that never jumps;
- no drive in the back-off state or with nothing pending;
- a release in the cycle arbitration is lost;
- won as an isolated pulse never paired with lost;
- a self-made START only when the bus was available;
- a cleared request at each delivery pulse.

The rest needs the bench's bus model, with a controller and a rival target sharing a wired-AND line. That covers:
- the header bit order and which address the wire shows;
- the payload and end-of-data bit values;
- ignoring STARTs between a loss and the next bus-available;
- the delay before a self-made START;
- the payload held against a second request.

// File: rtl/ibi_pkg.sv
package ibi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,    // nothing in flight
    ST_SSTART,  // own START held on SDA
    ST_HDR,     // address header + read bit
    ST_ACK,     // ninth header bit from controller
    ST_DATA,    // payload bits
    ST_TBIT,    // end-of-data bit
    ST_TREL,    // hold end-of-data low until SCL falls
    ST_BACK     // waiting for bus-available before retry
  } ibi_state_e;

endpackage

// File: rtl/ibi_bus_mon.sv
module ibi_bus_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] avail_limit,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             start_det,
  output logic             stop_det,
  output logic             avail
);

  logic             scl_q;
  logic             sda_q;
  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      idle_cnt <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (!(scl_i && sda_i))
        idle_cnt <= '0;
      else if (tick_i && (idle_cnt < avail_limit))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign scl_fall  = scl_q && !scl_i;
  assign scl_rise  = !scl_q && scl_i;
  assign start_det = scl_q && scl_i && sda_q && !sda_i;
  assign stop_det  = scl_q && scl_i && !sda_q && sda_i;
  assign avail     = (avail_limit != '0) && (idle_cnt >= avail_limit);

  // R6
  avail_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> (scl_q && sda_q));

  // R6
  idle_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt != '0) |-> ((idle_cnt == $past(idle_cnt)) ||
                          (idle_cnt == $past(idle_cnt) + 1'b1)));

endmodule

// File: rtl/ibi_fsm.sv
module ibi_fsm
  import ibi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_fall,
  input  logic              scl_rise,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              avail,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_has_byte,
  input  logic [DATA_W-1:0] req_byte,
  output logic              sda_pull,
  output logic              won,
  output logic              lost,
  output logic              sent
);

  localparam int HDR_W = ADDR_W + 1;
  localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int IDX_W = $clog2(SH_W + 1);

  ibi_state_e        state;
  logic              pending;
  logic              has_q;
  logic [DATA_W-1:0] pay_q;
  logic [SH_W-1:0]   sh;
  logic [IDX_W-1:0]  idx;
  logic [SH_W-1:0]   hdr_word;
  logic [SH_W-1:0]   pay_word;
  logic              cur_bit;

  // header and payload left-aligned so the MSB always leaves first
  assign hdr_word  = SH_W'({dyn_addr, 1'b1}) << (SH_W - HDR_W);
  assign pay_word  = SH_W'(pay_q) << (SH_W - DATA_W);
  assign cur_bit   = sh[SH_W-1];
  assign req_ready = !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pending  <= 1'b0;
      has_q    <= 1'b0;
      pay_q    <= '0;
      sh       <= '0;
      idx      <= '0;
      sda_pull <= 1'b0;
      won      <= 1'b0;
      lost     <= 1'b0;
      sent     <= 1'b0;
    end else begin
      won  <= 1'b0;
      lost <= 1'b0;
      sent <= 1'b0;

      if (req_valid && !pending) begin
        pending <= 1'b1;
        has_q   <= req_has_byte;
        pay_q   <= req_byte;
      end

      case (state)
        ST_IDLE: begin
          sda_pull <= 1'b0;
          if (pending && start_det) begin
            sh    <= hdr_word;
            idx   <= '0;
            state <= ST_HDR;
          end else if (pending && avail) begin
            sda_pull <= 1'b1;
            state    <= ST_SSTART;
          end
        end

        ST_SSTART: begin
          if (start_det) begin
            sh    <= hdr_word;
            idx   <= '0;
            state <= ST_HDR;
          end
        end

        ST_HDR: begin
          if (stop_det) begin
            sda_pull <= 1'b0;
            state    <= ST_BACK;
          end else if (scl_fall) begin
            sda_pull <= !cur_bit;
          end else if (scl_rise) begin
            if (cur_bit && !sda_i) begin
              lost     <= 1'b1;
              sda_pull <= 1'b0;
              state    <= ST_BACK;
            end else begin
              sh  <= sh << 1;
              idx <= idx + 1'b1;
              if (idx == IDX_W'(HDR_W - 1)) begin
                won   <= 1'b1;
                state <= ST_ACK;
              end
            end
          end
        end

        ST_ACK: begin
          if (stop_det) begin
            sda_pull <= 1'b0;
            state    <= ST_BACK;
          end else if (scl_fall) begin
            sda_pull <= 1'b0;
          end else if (scl_rise) begin
            if (sda_i) begin
              state <= ST_BACK;
            end else if (has_q) begin
              sh    <= pay_word;
              idx   <= '0;
              state <= ST_DATA;
            end else begin
              sent    <= 1'b1;
              pending <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end

        ST_DATA: begin
          if (stop_det) begin
            sda_pull <= 1'b0;
            state    <= ST_BACK;
          end else if (scl_fall) begin
            sda_pull <= !cur_bit;
          end else if (scl_rise) begin
            sh  <= sh << 1;
            idx <= idx + 1'b1;
            if (idx == IDX_W'(DATA_W - 1))
              state <= ST_TBIT;
          end
        end

        ST_TBIT: begin
          if (stop_det) begin
            sda_pull <= 1'b0;
            state    <= ST_BACK;
          end else if (scl_fall) begin
            sda_pull <= 1'b1;
          end else if (scl_rise) begin
            sent    <= 1'b1;
            pending <= 1'b0;
            state   <= ST_TREL;
          end
        end

        ST_TREL: begin
          if (scl_fall || stop_det || start_det) begin
            sda_pull <= 1'b0;
            state    <= ST_IDLE;
          end
        end

        ST_BACK: begin
          sda_pull <= 1'b0;
          if (avail)
            state <= ST_IDLE;
        end

        default: begin
          sda_pull <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  // R3
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !sda_pull);

  // R4
  won_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    won |=> !won);

  // R4
  won_lost_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(won && lost));

  // R5
  backoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACK) |-> !sda_pull);

  // R7
  self_start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && $past(state == ST_IDLE)) |-> $past(avail));

  // R9
  sent_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent |-> req_ready);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && (state == ST_IDLE)) |-> !sda_pull);

endmodule

// File: rtl/ibi_requester.sv
module ibi_requester #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  avail_limit,
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_has_byte,
  input  logic [DATA_W-1:0] req_byte,
  output logic              sda_pull_o,
  output logic              won_o,
  output logic              lost_o,
  output logic              sent_o
);

  logic scl_fall;
  logic scl_rise;
  logic start_det;
  logic stop_det;
  logic avail;

  ibi_bus_mon #(
    .CNT_W (CNT_W)
  ) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .tick_i      (tick_i),
    .avail_limit (avail_limit),
    .scl_fall    (scl_fall),
    .scl_rise    (scl_rise),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .avail       (avail)
  );

  ibi_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_fall     (scl_fall),
    .scl_rise     (scl_rise),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .avail        (avail),
    .sda_i        (sda_i),
    .dyn_addr     (dyn_addr),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_has_byte (req_has_byte),
    .req_byte     (req_byte),
    .sda_pull     (sda_pull_o),
    .won          (won_o),
    .lost         (lost_o),
    .sent         (sent_o)
  );

endmodule

// File: tb/ibi_requester_bench.sv
`timescale 1ns/1ps
module ibi_requester_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       ctl_sda = 1'b1;
  logic       oth_pull = 1'b0;
  logic       tick = 1'b0;
  logic [15:0] limit = 16'd20;
  logic [6:0] dyn_addr = 7'h35;
  logic       req_valid = 1'b0;
  logic       req_has = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       req_ready;
  logic       sda_pull;
  logic       won_o, lost_o, sent_o;
  logic       sda;

  always #2 clk = ~clk;

  assign sda = ctl_sda & ~sda_pull & ~oth_pull;

  ibi_requester u_ibi_requester (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda),
    .tick_i       (tick),
    .avail_limit  (limit),
    .dyn_addr     (dyn_addr),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_has_byte (req_has),
    .req_byte     (req_byte),
    .sda_pull_o   (sda_pull),
    .won_o        (won_o),
    .lost_o       (lost_o),
    .sent_o       (sent_o)
  );

  int   n_cmp = 0;
  int   n_mis = 0;
  int   won_n = 0, lost_n = 0, sent_n = 0, pull_cyc = 0;
  bit   finished = 0;
  bit   oth_alive = 0;
  bit   pend = 0;
  logic [6:0] cur_addr = 7'h35;
  bit   cur_has = 0;
  logic [7:0] cur_byte = 8'h00;

  always @(negedge clk) begin
    if (won_o)    won_n++;
    if (lost_o)   lost_n++;
    if (sent_o)   sent_n++;
    if (sda_pull) pull_cyc++;
  end

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input logic [6:0] a, input bit h, input logic [7:0] b);
    dyn_addr = a; cur_addr = a; cur_has = h; cur_byte = b;
    req_has = h; req_byte = b; req_valid = 1'b1;
    cyc(1);
    req_valid = 1'b0;
    pend = 1;
  endtask

  task automatic bus_start;
    ctl_sda = 1'b0;
    cyc(4);
    scl = 1'b0;
    cyc(2);
  endtask

  task automatic bus_stop;
    ctl_sda = 1'b0;
    oth_pull = 1'b0;
    cyc(2);
    scl = 1'b1;
    cyc(3);
    ctl_sda = 1'b1;
    cyc(3);
  endtask

  task automatic bit_xfer(input logic cbit, input logic obit, output logic s);
    cyc(2);
    ctl_sda = cbit;
    oth_pull = oth_alive && !obit;
    cyc(3);
    scl = 1'b1;
    cyc(3);
    s = sda;
    if (oth_alive && obit && !s) oth_alive = 0;
    cyc(3);
    scl = 1'b0;
  endtask

  // expected wire content: wired-AND of MSB-first headers = smaller word
  function automatic logic [7:0] exp_hdr(input bit me_on, input logic [7:0] mh,
                                         input bit oth_on, input logic [7:0] oh);
    if (me_on && oth_on) return (mh < oh) ? mh : oh;
    if (me_on)           return mh;
    if (oth_on)          return oh;
    return 8'hFF;
  endfunction

  task automatic frame(input bit me_on, input bit oth_on, input logic [6:0] oa,
                       input bit ack, input string tag);
    logic [7:0] mh, oh, got, dat;
    logic s;
    bit win;
    int w0, l0, s0, p0;
    mh = {cur_addr, 1'b1};
    oh = {oa, 1'b1};
    win = me_on && (!oth_on || (mh < oh));
    w0 = won_n; l0 = lost_n; s0 = sent_n; p0 = pull_cyc;
    oth_alive = oth_on;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, oh[i], s);
      got[i] = s;
    end
    oth_alive = 0;
    check({tag, " R2 header on wire"}, got, exp_hdr(me_on, mh, oth_on, oh));
    check({tag, " R4 won pulses"}, won_n - w0, win);
    check({tag, " R3 lost pulses"}, lost_n - l0, me_on && !win);
    bit_xfer(!ack, 1'b1, s);
    if (win && ack && cur_has) begin
      for (int i = 7; i >= 0; i--) begin
        bit_xfer(1'b1, 1'b1, s);
        dat[i] = s;
      end
      check({tag, " R8 payload byte"}, dat, cur_byte);
      bit_xfer(1'b1, 1'b1, s);
      check({tag, " R8 end-of-data bit"}, s, 0);
    end
    bus_stop;
    if (win && ack) pend = 0;
    check({tag, " R9 sent pulses"}, sent_n - s0, win && ack);
    check({tag, " R1 ready level"}, req_ready, !pend);
    if (!me_on)
      check({tag, " R10/R5 no drive"}, pull_cyc - p0, 0);
  endtask

  task automatic self_resolve(input string tag, input bit chk_dly);
    int dly;
    dly = 0;
    tick = 1'b1;
    while (!sda_pull && dly < int'(limit) + 60) begin
      cyc(1);
      dly++;
    end
    check({tag, " R7 own START (pull,scl,sda)"}, {sda_pull, scl, sda}, 3'b110);
    if (chk_dly)
      check({tag, " R6 bus-available delay in range"},
            (dly >= int'(limit)) && (dly <= int'(limit) + 3), 1);
    ctl_sda = 1'b0;
    cyc(2);
    scl = 1'b0;
    tick = 1'b0;
    cyc(2);
    frame(1, 0, 7'h00, 1, {tag, " retry"});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [6:0] a, o;
    bit on, ack, h;
    logic [7:0] b;
    void'($urandom(32'h1D5EED));

    cyc(5);
    rst_n = 1'b1;
    cyc(3);

    // reset state
    check("R1 reset ready", req_ready, 1);
    check("R10 reset pull", sda_pull, 0);
    check("R4 reset flags", {won_o, lost_o, sent_o}, 0);

    // R10: no request, a rival's frame
    bus_start;
    frame(0, 1, 7'h22, 1, "idle-rival");

    // R2 R4 R9: plain request, no payload
    request(7'h35, 0, 8'h00);
    check("R1 ready after accept", req_ready, 0);
    bus_start;
    frame(1, 0, 7'h00, 1, "solo");

    // R8: payload, rival with a higher address loses
    request(7'h35, 1, 8'hA6);
    bus_start;
    frame(1, 1, 7'h50, 1, "win-payload");

    // R3: lower rival wins; R1: second offer ignored; R5: next START ignored
    request(7'h35, 1, 8'h5C);
    bus_start;
    frame(1, 1, 7'h12, 1, "lose");
    check("R1 ready while pending", req_ready, 0);
    req_has = 1'b0; req_byte = 8'h99; req_valid = 1'b1;
    cyc(1);
    req_valid = 1'b0;
    cyc(2);
    bus_start;
    frame(0, 1, 7'h40, 1, "R5 backoff");
    self_resolve("lose", 1);

    // R5: NACK keeps the request, retried after bus-available
    request(7'h0B, 0, 8'h00);
    bus_start;
    frame(1, 0, 7'h00, 0, "nack");
    check("R5 pending after NACK", req_ready, 0);
    self_resolve("nack", 1);

    // R6: limit 0 disables own START
    request(7'h61, 1, 8'h3C);
    limit = 16'd0;
    tick = 1'b1;
    p0 = pull_cyc;
    cyc(80);
    check("R6 limit zero keeps bus untouched", pull_cyc - p0, 0);
    tick = 1'b0;
    limit = 16'd20;
    cyc(2);
    self_resolve("limit", 1);

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      a = 7'($urandom % 128);
      o = 7'($urandom % 128);
      if (o == a) o = o ^ 7'h01;
      on  = ($urandom % 2) == 1;
      ack = ($urandom % 4) != 0;
      h   = ($urandom % 2) == 1;
      b   = 8'($urandom % 256);
      limit = 16'(8 + ($urandom % 24));
      request(a, h, b);
      cyc(3);
      bus_start;
      frame(1, on, o, ack, "rand");
      if (pend) self_resolve("rand", 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule